// File: doc/BRIEF.md
# SECDED Protected Memory Controller with Partial-Write Merge

This block puts a 64-bit word memory behind an error-correcting wrapper. Each stored word carries 8 check bits from an extended Hamming (72,64) code. A read returns the word in the cycle after the request. Any single flipped bit is repaired on the way out, and a response flag reports the repair. When two bits are flipped, the block flags the response, records the event in sticky status and raises an interrupt.

Writes carry byte enables. A write that covers all eight bytes with checking on stores fresh check bits. A write that covers only some bytes can be handled in two ways, chosen by a configuration input. In the first, the controller reads the old word, repairs it, merges in the new bytes and writes the whole word back with new check bits, stalling the host for one cycle. In the second, it stores only the selected bytes and leaves the check bits untouched.

While checking is switched off, writes change data bits only and reads return raw stored data. Self-test software uses this to plant known one-bit and two-bit faults and then confirm that, with checking back on, they are repaired or reported. Status holds the word address of the first correctable and of the first uncorrectable event until software clears it.

Top module: `secded_mem_ctrl`

## Requirements
- R1: With checking on (ecc_en_i=1), a write with be_i=8'hFF followed by a read of the same address returns the written word, with rsp_ce_o=0 and rsp_ue_o=0.
- R2: If exactly one data bit of a stored word differs from the word last written with checking on, a read with checking on returns the original word, pulses rsp_ce_o=1 with rsp_ue_o=0, and sets ce_o on the following cycle.
- R3: If exactly two data bits differ, a read with checking on gives rsp_ue_o=1 and rsp_ce_o=0, and on the following cycle ue_o=1 and irq_o=1.
- R4: A write with checking off (ecc_en_i=0) changes only the bytes selected by be_i (bit b selects data bits 8b+7..8b) and leaves the check bits as they were. A read with checking off returns the raw stored word, keeps both response flags at 0 and leaves the status unchanged.
- R5: With checking on and rmw_en_i=0, a partial write (be_i not all ones) stores the selected bytes and leaves the check bits stale. It raises no flag and does not stall. A later read that differs from the last fully coded word in one bit returns that old word with rsp_ce_o=1.
- R6: With checking on and rmw_en_i=1, a partial write drives ready_o to 0 for exactly one cycle. It stores the merged word: new bytes where be_i is set, and the repaired old bytes elsewhere. It also stores matching check bits, so a later read returns the merged word without flags.
- R7: ce_addr_o takes the address of the first correctable event after a clear and keeps it through later correctable events.
- R8: ue_addr_o takes the address of the first uncorrectable event after a clear and keeps it through later uncorrectable events.
- R9: A cycle with status_clr_i=1 sets ce_o, ue_o, irq_o, ce_addr_o and ue_addr_o to 0 on the next cycle. If an error is seen in the same cycle, the clear wins.
- R10: During and after reset, ready_o=1, rvalid_o=0 and all status outputs are 0.
- R11: An accepted read (req_i=1, we_i=0 while ready_o=1) gives rvalid_o=1 on exactly the next cycle, and rvalid_o is 1 only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ecc_en_i | input | 1 | Checking enable, sampled with each request |
| rmw_en_i | input | 1 | Merge partial writes by read-modify-write |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| be_i | input | 8 | Byte enables for writes |
| wdata_i | input | 64 | Write data |
| ready_o | output | 1 | Request accepted when high |
| rvalid_o | output | 1 | Read response valid |
| rdata_o | output | 64 | Read data, repaired when checking is on |
| rsp_ce_o | output | 1 | Response carried a corrected error |
| rsp_ue_o | output | 1 | Response carried an uncorrectable error |
| status_clr_i | input | 1 | Clear sticky status |
| ce_o | output | 1 | Sticky correctable-error flag |
| ue_o | output | 1 | Sticky uncorrectable-error flag |
| ce_addr_o | output | ADDR_W | Address of first correctable error |
| ue_addr_o | output | ADDR_W | Address of first uncorrectable error |
| irq_o | output | 1 | Interrupt on uncorrectable error |

## Verification
The bench builds the block with its default ADDR_W=4, which gives a 16-word memory. With a memory that small, every address can be written and read back in a short run. The full 64-bit data width is kept, so every single-bit fault position can be tested, all 64 of them, along with all 2016 two-bit combinations, each planted through a write made with checking off. The expected repaired words and merged words are built in the bench from XOR and byte masks alone.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int BE_W   = DATA_W / 8;
  localparam int CW_POS = DATA_W + HAM_W;

  typedef enum logic {ST_IDLE, ST_MERGE} ctrl_st_e;

  // codeword position (1-based) of data bit idx; powers of two hold check bits
  function automatic int unsigned data_pos(int idx);
    int unsigned pos;
    int n;
    pos = 0;
    n = 0;
    for (int p = 1; p <= CW_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) pos = p;
        n++;
      end
    end
    return pos;
  endfunction

  function automatic logic [HAM_W-1:0] ham_bits(logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int unsigned p;
    h = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p = data_pos(i);
      for (int b = 0; b < HAM_W; b++)
        if (p[b]) h[b] = h[b] ^ d[i];
    end
    return h;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [HAM_W-1:0] ham;
  assign ham   = ham_bits(data_i);
  assign chk_o = {(^data_i) ^ (^ham), ham};
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  logic [HAM_W-1:0] syn;
  logic             ovr;
  logic             in_range;

  assign syn      = ham_bits(data_i) ^ chk_i[HAM_W-1:0];
  assign ovr      = ^{data_i, chk_i};
  assign in_range = (int'(syn) <= CW_POS);
  assign single_o = ovr & in_range;
  assign double_o = (~ovr & (syn != '0)) | (ovr & ~in_range);

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
    assign data_o[i] = data_i[i] ^ (ovr & (syn == POS));
  end
endmodule

// File: rtl/secded_mem_array.sv
module secded_mem_array
  import secded_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CHK_W-1:0]  rchk_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [BE_W-1:0]   wbe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              chk_we_i,
  input  logic [CHK_W-1:0]  wchk_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [CHK_W-1:0]  chk_mem  [DEPTH];

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk_i)
      if (we_i && wbe_i[b]) data_mem[waddr_i][8*b +: 8] <= wdata_i[8*b +: 8];
  end

  always_ff @(posedge clk_i)
    if (we_i && chk_we_i) chk_mem[waddr_i] <= wchk_i;

  always_ff @(posedge clk_i)
    if (rd_en_i) begin
      rdata_o <= data_mem[raddr_i];
      rchk_o  <= chk_mem[raddr_i];
    end
endmodule

// File: rtl/secded_mem_ctrl.sv
module secded_mem_ctrl
  import secded_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ecc_en_i,
  input  logic              rmw_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rsp_ce_o,
  output logic              rsp_ue_o,
  input  logic              status_clr_i,
  output logic              ce_o,
  output logic              ue_o,
  output logic [ADDR_W-1:0] ce_addr_o,
  output logic [ADDR_W-1:0] ue_addr_o,
  output logic              irq_o
);
  ctrl_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic              rvalid_q, rd_ecc_q;
  logic              ce_q, ue_q;
  logic [ADDR_W-1:0] ce_addr_q, ue_addr_q;

  logic accept, rd_acc, full_wr, rmw_go, direct_wr, in_merge;
  assign in_merge  = (st_q == ST_MERGE);
  assign ready_o   = ~in_merge;
  assign accept    = req_i & ready_o;
  assign rd_acc    = accept & ~we_i;
  assign full_wr   = &be_i;
  assign rmw_go    = accept & we_i & ecc_en_i & rmw_en_i & ~full_wr;
  assign direct_wr = accept & we_i & ~rmw_go;

  logic [DATA_W-1:0] mem_rdata, fix_data, merged, mem_wdata, enc_in;
  logic [CHK_W-1:0]  mem_rchk, enc_chk;
  logic              dec_single, dec_double;
  logic              mem_we, mem_chk_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [BE_W-1:0]   mem_wbe;

  for (genvar b = 0; b < BE_W; b++) begin : g_merge
    assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : fix_data[8*b +: 8];
  end

  always_comb begin
    if (in_merge) begin
      mem_we     = 1'b1;
      mem_waddr  = addr_q;
      mem_wbe    = '1;
      mem_wdata  = merged;
      mem_chk_we = 1'b1;
    end else begin
      mem_we     = direct_wr;
      mem_waddr  = addr_i;
      mem_wbe    = be_i;
      mem_wdata  = wdata_i;
      mem_chk_we = ecc_en_i & full_wr;
    end
  end
  assign enc_in = in_merge ? merged : wdata_i;

  secded_enc u_enc (.data_i(enc_in), .chk_o(enc_chk));

  secded_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i    (clk_i),
    .rd_en_i  (rd_acc | rmw_go),
    .raddr_i  (addr_i),
    .rdata_o  (mem_rdata),
    .rchk_o   (mem_rchk),
    .we_i     (mem_we),
    .waddr_i  (mem_waddr),
    .wbe_i    (mem_wbe),
    .wdata_i  (mem_wdata),
    .chk_we_i (mem_chk_we),
    .wchk_i   (enc_chk)
  );

  secded_dec u_dec (
    .data_i   (mem_rdata),
    .chk_i    (mem_rchk),
    .data_o   (fix_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      rvalid_q <= 1'b0;
      rd_ecc_q <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (accept) begin
        addr_q   <= addr_i;
        rd_ecc_q <= ecc_en_i;
      end
      if (rmw_go) begin
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
      st_q <= rmw_go ? ST_MERGE : ST_IDLE;
    end
  end

  logic chk_live;
  assign chk_live = (rvalid_q & rd_ecc_q) | in_merge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b0;
      ue_q      <= 1'b0;
      ce_addr_q <= '0;
      ue_addr_q <= '0;
    end else if (status_clr_i) begin
      ce_q      <= 1'b0;
      ue_q      <= 1'b0;
      ce_addr_q <= '0;
      ue_addr_q <= '0;
    end else if (chk_live) begin
      if (dec_single && !ce_q) begin
        ce_q      <= 1'b1;
        ce_addr_q <= addr_q;
      end
      if (dec_double && !ue_q) begin
        ue_q      <= 1'b1;
        ue_addr_q <= addr_q;
      end
    end
  end

  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rd_ecc_q ? fix_data : mem_rdata;
  assign rsp_ce_o  = rvalid_q & rd_ecc_q & dec_single;
  assign rsp_ue_o  = rvalid_q & rd_ecc_q & dec_double;
  assign ce_o      = ce_q;
  assign ue_o      = ue_q;
  assign ce_addr_o = ce_addr_q;
  assign ue_addr_o = ue_addr_q;
  assign irq_o     = ue_q;
endmodule

// File: rtl/secded_mem_ctrl_chk.sv
module secded_mem_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic              rsp_ce_o,
  input logic              rsp_ue_o,
  input logic              status_clr_i,
  input logic              ce_o,
  input logic              ue_o,
  input logic [ADDR_W-1:0] ce_addr_o,
  input logic [ADDR_W-1:0] ue_addr_o,
  input logic              irq_o
);
  AST_RD_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !we_i) |=> rvalid_o); // R11
  AST_RVALID_ONLY_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && ready_o && !we_i)); // R11
  AST_RMW_ONE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_ce_o && rsp_ue_o)); // R2
  AST_UE_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && rsp_ue_o && !status_clr_i) |=> (irq_o && ue_o)); // R3
  AST_CE_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_o && $past(ce_o) && !$past(status_clr_i)) |-> $stable(ce_addr_o)); // R7
  AST_UE_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_o && $past(ue_o) && !$past(status_clr_i)) |-> $stable(ue_addr_o)); // R8
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_clr_i |=> (!ce_o && !ue_o && !irq_o)); // R9
endmodule

bind secded_mem_ctrl secded_mem_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .ready_o(ready_o), .rvalid_o(rvalid_o), .rsp_ce_o(rsp_ce_o),
  .rsp_ue_o(rsp_ue_o), .status_clr_i(status_clr_i), .ce_o(ce_o),
  .ue_o(ue_o), .ce_addr_o(ce_addr_o), .ue_addr_o(ue_addr_o), .irq_o(irq_o)
);

// File: tb/secded_mem_ctrl_tb_top.sv
module secded_mem_ctrl_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_en = 1'b1, rmw_en = 1'b0, req = 1'b0, we = 1'b0, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    be = '0;
  logic [63:0]   wdata = '0;
  logic ready, rvalid, rsp_ce, rsp_ue, ce, ue, irq;
  logic [63:0]   rdata;
  logic [AW-1:0] ce_addr, ue_addr;

  always #5 clk = ~clk;

  secded_mem_ctrl #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ecc_en_i(ecc_en), .rmw_en_i(rmw_en),
    .req_i(req), .we_i(we), .addr_i(addr), .be_i(be), .wdata_i(wdata),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata), .rsp_ce_o(rsp_ce),
    .rsp_ue_o(rsp_ue), .status_clr_i(clr), .ce_o(ce), .ue_o(ue),
    .ce_addr_o(ce_addr), .ue_addr_o(ue_addr), .irq_o(irq)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lane_mask(input logic [7:0] b);
    logic [63:0] m = '0;
    for (int i = 0; i < 8; i++) if (b[i]) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  // returns ready sampled in the cycle after the accepting edge
  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] b,
                    input logic e, input logic r, output logic rdy_after);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b; ecc_en = e; rmw_en = r;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rdy_after = ready;
    while (!ready) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic e, output logic [63:0] d,
                    output logic fce, output logic fue, output logic vld);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; ecc_en = e;
    @(negedge clk);
    req = 1'b0;
    vld = rvalid; d = rdata; fce = rsp_ce; fue = rsp_ue;
    @(negedge clk);
    ecc_en = 1'b1;
  endtask

  task automatic clear_status();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d, base, exp;
    logic fce, fue, vld, rdy;

    repeat (3) @(negedge clk);
    // R10 reset state
    check(ready === 1'b1 && rvalid === 1'b0, "R10 ready/rvalid in reset", {ready, rvalid}, 2'b10);
    check({ce, ue, irq} === 3'b000 && ce_addr === '0 && ue_addr === '0, "R10 status in reset",
          {ce, ue, irq, ce_addr, ue_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1 && rvalid === 1'b0, "R10 after reset", {ready, rvalid}, 2'b10);

    // R1 every address, distinct patterns; R11 response timing
    for (int a = 0; a < 16; a++) begin
      base = 64'h9E37_79B9_7F4A_7C15 * (a + 1);
      wr(AW'(a), base, 8'hFF, 1'b1, 1'b0, rdy);
    end
    for (int a = 0; a < 16; a++) begin
      base = 64'h9E37_79B9_7F4A_7C15 * (a + 1);
      rd(AW'(a), 1'b1, d, fce, fue, vld);
      check(vld === 1'b1, "R11 rvalid one cycle after read", vld, 1);
      check(rvalid === 1'b0, "R11 rvalid single pulse", rvalid, 0);
      check(d === base && !fce && !fue, "R1 clean readback", d, base);
    end

    // R2/R4 every single data-bit fault
    base = 64'h0123_4567_89AB_CDEF;
    for (int i = 0; i < 64; i++) begin
      wr(4'd5, base, 8'hFF, 1'b1, 1'b0, rdy);
      wr(4'd5, base ^ (64'd1 << i), 8'hFF, 1'b0, 1'b0, rdy);
      rd(4'd5, 1'b0, d, fce, fue, vld);
      check(d === (base ^ (64'd1 << i)) && !fce && !fue, "R4 raw read with checking off", d, base ^ (64'd1 << i));
      check(!ce && !ue, "R4 raw read leaves status", {ce, ue}, 0);
      rd(4'd5, 1'b1, d, fce, fue, vld);
      check(d === base, "R2 single bit corrected", d, base);
      check(fce === 1'b1 && fue === 1'b0, "R2 response flags", {fce, fue}, 2'b10);
      check(ce === 1'b1 && ue === 1'b0 && irq === 1'b0, "R2 sticky ce", {ce, ue, irq}, 3'b100);
      clear_status();
    end

    // R3 every two-bit data fault
    for (int i = 0; i < 64; i++) begin
      for (int j = i + 1; j < 64; j++) begin
        wr(4'd6, base, 8'hFF, 1'b1, 1'b0, rdy);
        wr(4'd6, base ^ (64'd1 << i) ^ (64'd1 << j), 8'hFF, 1'b0, 1'b0, rdy);
        rd(4'd6, 1'b1, d, fce, fue, vld);
        check(fue === 1'b1 && fce === 1'b0, "R3 double flagged", {fce, fue}, 2'b01);
        check(ue === 1'b1 && irq === 1'b1, "R3 sticky ue and irq", {ue, irq}, 2'b11);
        clear_status();
      end
    end

    // R4 byte enables with checking off select lanes only
    wr(4'd4, 64'h1111_2222_3333_4444, 8'hFF, 1'b1, 1'b0, rdy);
    wr(4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 8'h81, 1'b0, 1'b0, rdy);
    rd(4'd4, 1'b0, d, fce, fue, vld);
    exp = 64'hFF11_2222_3333_44FF;
    check(d === exp, "R4 lane-selective write", d, exp);

    // R5 partial write without merge: stale check bits
    base = 64'hDEAD_BEEF_CAFE_F00D;
    wr(4'd7, base, 8'hFF, 1'b1, 1'b0, rdy);
    exp = base ^ 64'h0000_0000_0010_0000;
    wr(4'd7, exp, 8'h04, 1'b1, 1'b0, rdy);
    check(rdy === 1'b1, "R5 no stall", rdy, 1);
    check(!ce && !ue && !irq, "R5 no error at write", {ce, ue, irq}, 0);
    rd(4'd7, 1'b0, d, fce, fue, vld);
    check(d === exp, "R5 selected byte stored", d, exp);
    rd(4'd7, 1'b1, d, fce, fue, vld);
    check(d === base && fce === 1'b1, "R5 stale check restores old word", d, base);
    clear_status();

    // R6 partial write with merge
    base = 64'h0F0F_0F0F_0F0F_0F0F;
    wdata = 64'h0;
    wr(4'd8, base, 8'hFF, 1'b1, 1'b0, rdy);
    wr(4'd8, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0C, 1'b1, 1'b1, rdy);
    check(rdy === 1'b0, "R6 one-cycle stall", rdy, 0);
    check(ready === 1'b1, "R6 ready returns", ready, 1);
    exp = (base & ~lane_mask(8'h0C)) | (64'hAAAA_BBBB_CCCC_DDDD & lane_mask(8'h0C));
    rd(4'd8, 1'b1, d, fce, fue, vld);
    check(d === exp && !fce && !fue, "R6 merged word coded", d, exp);
    // merge repairs an old single-bit fault in a kept lane
    wr(4'd9, base, 8'hFF, 1'b1, 1'b0, rdy);
    wr(4'd9, base ^ 64'h1, 8'h01, 1'b0, 1'b0, rdy);
    wr(4'd9, 64'h1234_5678_0000_0000, 8'hF0, 1'b1, 1'b1, rdy);
    check(ce === 1'b1 && ce_addr === 4'd9, "R6 merge logs repaired fault", {ce, ce_addr}, {1'b1, 4'd9});
    clear_status();
    exp = 64'h1234_5678_0F0F_0F0F;
    rd(4'd9, 1'b1, d, fce, fue, vld);
    check(d === exp && !fce && !fue, "R6 merged with repaired lanes", d, exp);

    // R7 first correctable address held
    clear_status();
    for (int a = 10; a < 12; a++) begin
      wr(AW'(a), base, 8'hFF, 1'b1, 1'b0, rdy);
      wr(AW'(a), base ^ 64'h8000, 8'hFF, 1'b0, 1'b0, rdy);
    end
    rd(4'd10, 1'b1, d, fce, fue, vld);
    check(ce_addr === 4'd10, "R7 first ce address", ce_addr, 10);
    rd(4'd11, 1'b1, d, fce, fue, vld);
    check(ce_addr === 4'd10 && ce === 1'b1, "R7 ce address held", ce_addr, 10);

    // R8 first uncorrectable address held
    for (int a = 12; a < 14; a++) begin
      wr(AW'(a), base, 8'hFF, 1'b1, 1'b0, rdy);
      wr(AW'(a), base ^ 64'h3, 8'hFF, 1'b0, 1'b0, rdy);
    end
    rd(4'd12, 1'b1, d, fce, fue, vld);
    check(ue_addr === 4'd12, "R8 first ue address", ue_addr, 12);
    rd(4'd13, 1'b1, d, fce, fue, vld);
    check(ue_addr === 4'd12 && ue === 1'b1, "R8 ue address held", ue_addr, 12);

    // R9 clear
    clear_status();
    check({ce, ue, irq} === 3'b000 && ce_addr === '0 && ue_addr === '0, "R9 clear",
          {ce, ue, irq, ce_addr, ue_addr}, 0);
    // R9 clear wins over a same-cycle error
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 4'd12; ecc_en = 1'b1;
    @(negedge clk);
    req = 1'b0; clr = 1'b1;
    check(rsp_ue === 1'b1, "R9 error present during clear", rsp_ue, 1);
    @(negedge clk);
    clr = 1'b0;
    check(ue === 1'b0 && irq === 1'b0, "R9 clear wins", {ue, irq}, 0);

    summary();
    $finish;
  end
endmodule